// File: doc/BRIEF.md
# Image Window Address Generator

This block walks a rectangular window of a bitmap held in a 16 MB byte-addressed image memory and issues one memory access per data beat, for an encoder that reads pixels or a decoder that writes them back. Software programs a 24-bit start address, the number of bytes to touch on each line, the distance in bytes between the starts of consecutive lines in the stored page, and the number of lines. Because the touched width and the line pitch are independent, any sub-window of a wider page can be coded.

After a start pulse the block latches its configuration and runs a small state machine. `ST_IDLE` waits for `start` and then goes to `ST_ADVANCE`. `ST_ADVANCE` takes one cycle to load the access pointer from the current line base, and always goes to `ST_XFER`. `ST_XFER` holds a request until `mem_rdy`. On an accepted beat it stays in `ST_XFER` while the line has bytes left, goes to `ST_ADVANCE` at the end of a line when lines remain, and returns to `ST_IDLE` after the last beat of the last line, setting the interrupt flag. On a 16-bit bus each beat covers an even-aligned byte pair, and byte strobes mark which half lies inside the window.

Top module: `winaddr_gen`

## Requirements
- R1: After reset `mem_req`, `busy` and `irq` are low.
- R2: A `start` pulse seen while idle latches all configuration inputs and raises `busy`. `busy` stays high until the final beat is accepted.
- R3: With `cfg_wide`=0 (8-bit bus), each line issues one beat per byte at consecutive addresses from the line base, with `mem_lo_en`=1 and `mem_hi_en`=0.
- R4: With `cfg_wide`=1 (16-bit bus), beats carry even addresses stepping by 2. `mem_lo_en` marks the even byte and `mem_hi_en` the odd byte (address+1). Each strobe is asserted only when that byte lies inside the line's window, so a window edge on an odd byte gives a single strobe.
- R5: Each line's base is the previous line base plus `cfg_stride_m1`+1, modulo 2^24. The number of bytes per line is `cfg_bytes_m1`+1.
- R6: Exactly `cfg_lines_m1`+1 lines are issued. After the last beat `irq` is set and `busy` drops.
- R7: `irq` stays set until `irq_clr` is pulsed, and a set in the same cycle wins over the clear.
- R8: `start` and configuration changes while `busy` is high have no effect on the running walk.
- R9: While `mem_req` is high and `mem_rdy` is low, `mem_req`, `mem_addr` and both strobes hold their values into the next cycle.
- R10: Every beat has at least one byte strobe asserted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start | input | 1 | Begin a walk (sampled only while idle) |
| cfg_base | input | 24 | Byte address of the first window byte |
| cfg_bytes_m1 | input | 13 | Bytes per line minus one |
| cfg_stride_m1 | input | 13 | Line pitch in bytes minus one |
| cfg_lines_m1 | input | 16 | Line count minus one |
| cfg_wide | input | 1 | 1 selects a 16-bit data bus, 0 an 8-bit bus |
| irq_clr | input | 1 | Clears the completion flag |
| mem_rdy | input | 1 | Memory accepts the current beat |
| mem_req | output | 1 | Beat request |
| mem_addr | output | 24 | Beat byte address (even when wide) |
| mem_lo_en | output | 1 | Lower (even) byte valid |
| mem_hi_en | output | 1 | Upper (odd) byte valid |
| busy | output | 1 | Walk in progress |
| irq | output | 1 | Completion flag |

## Verification
The bench goes after windows that start or end on odd bytes on the wide bus. A design that drops a strobe check would write a byte outside the window, and one that misaligns the pointer would skip or repeat a word. It uses a pitch that differs from the width and a walk that wraps past the top of the address space, so a design that steps from the current pointer rather than the line base, or that mishandles the carry, reads the wrong next line. A ready line that drops at random exposes any beat that moves before it is accepted. A mid-walk start with altered configuration shows whether the running walk is corrupted, and single-byte, single-line windows expose off-by-one errors in the counts.

// File: rtl/winaddr_pkg.sv
package winaddr_pkg;
    typedef enum logic [1:0] {
        ST_IDLE    = 2'd0,
        ST_ADVANCE = 2'd1,
        ST_XFER    = 2'd2
    } wa_state_e;
endpackage

// File: rtl/winaddr_lines.sv
// Line base register, line countdown and per-line end address.
module winaddr_lines #(
    parameter int AW = 24,
    parameter int BW = 13,
    parameter int NW = 16
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          load,
    input  logic          advance,
    input  logic [AW-1:0] cfg_base,
    input  logic [BW-1:0] cfg_bytes_m1,
    input  logic [BW-1:0] cfg_stride_m1,
    input  logic [NW-1:0] cfg_lines_m1,
    output logic [AW-1:0] line_base,
    output logic [AW-1:0] line_end,
    output logic          last_line
);
    logic [AW-1:0] base_q;
    logic [BW-1:0] bytes_q;
    logic [BW-1:0] stride_q;
    logic [NW-1:0] left_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            base_q   <= '0;
            bytes_q  <= '0;
            stride_q <= '0;
            left_q   <= '0;
        end else if (load) begin
            base_q   <= cfg_base;
            bytes_q  <= cfg_bytes_m1;
            stride_q <= cfg_stride_m1;
            left_q   <= cfg_lines_m1;
        end else if (advance) begin
            // next line is measured from the old line base, not the pointer
            base_q <= base_q + AW'(stride_q) + AW'(1);
            left_q <= left_q - NW'(1);
        end
    end

    assign line_base = base_q;
    assign line_end  = base_q + AW'(bytes_q);
    assign last_line = (left_q == '0);

    a_r6_no_extra_line: assert property (@(posedge clk) disable iff (!rst_n)
        advance |-> !last_line)
        else $error("line step past the final line");
endmodule

// File: rtl/winaddr_strobe.sv
// Byte strobes and end-of-line detection for the current beat.
module winaddr_strobe #(
    parameter int AW = 24
) (
    input  logic [AW-1:0] ptr,
    input  logic [AW-1:0] line_base,
    input  logic [AW-1:0] line_end,
    input  logic          wide,
    output logic          lo_en,
    output logic          hi_en,
    output logic          line_done
);
    logic [AW-1:0] base_even;
    assign base_even = {line_base[AW-1:1], 1'b0};

    always_comb begin
        if (wide) begin
            lo_en     = !(line_base[0] && (ptr == base_even));
            hi_en     = (ptr != line_end);
            line_done = (ptr[AW-1:1] == line_end[AW-1:1]);
        end else begin
            lo_en     = 1'b1;
            hi_en     = 1'b0;
            line_done = (ptr == line_end);
        end
    end
endmodule

// File: rtl/winaddr_gen.sv
module winaddr_gen
    import winaddr_pkg::*;
#(
    parameter int AW = 24,
    parameter int BW = 13,
    parameter int NW = 16
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          start,
    input  logic [AW-1:0] cfg_base,
    input  logic [BW-1:0] cfg_bytes_m1,
    input  logic [BW-1:0] cfg_stride_m1,
    input  logic [NW-1:0] cfg_lines_m1,
    input  logic          cfg_wide,
    input  logic          irq_clr,
    input  logic          mem_rdy,
    output logic          mem_req,
    output logic [AW-1:0] mem_addr,
    output logic          mem_lo_en,
    output logic          mem_hi_en,
    output logic          busy,
    output logic          irq
);
    localparam logic [AW-1:0] STEP_NARROW = AW'(1);
    localparam logic [AW-1:0] STEP_WIDE   = AW'(2);

    wa_state_e     state_q, state_d;
    logic [AW-1:0] ptr_q;
    logic          wide_q;
    logic          irq_q;

    logic [AW-1:0] line_base, line_end;
    logic          last_line, line_done, lo_en, hi_en;
    logic          accept, do_load, do_advance, finish;

    assign accept     = (state_q == ST_XFER) && mem_rdy;
    assign do_load    = (state_q == ST_IDLE) && start;
    assign do_advance = accept && line_done && !last_line;
    assign finish     = accept && line_done && last_line;

    winaddr_lines #(.AW(AW), .BW(BW), .NW(NW)) u_lines (
        .clk          (clk),
        .rst_n        (rst_n),
        .load         (do_load),
        .advance      (do_advance),
        .cfg_base     (cfg_base),
        .cfg_bytes_m1 (cfg_bytes_m1),
        .cfg_stride_m1(cfg_stride_m1),
        .cfg_lines_m1 (cfg_lines_m1),
        .line_base    (line_base),
        .line_end     (line_end),
        .last_line    (last_line)
    );

    winaddr_strobe #(.AW(AW)) u_strobe (
        .ptr      (ptr_q),
        .line_base(line_base),
        .line_end (line_end),
        .wide     (wide_q),
        .lo_en    (lo_en),
        .hi_en    (hi_en),
        .line_done(line_done)
    );

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    // transitions
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE:    if (start) state_d = ST_ADVANCE;
            ST_ADVANCE: state_d = ST_XFER;
            ST_XFER: begin
                if (finish)          state_d = ST_IDLE;
                else if (do_advance) state_d = ST_ADVANCE;
            end
            default:    state_d = ST_IDLE;
        endcase
    end

    // pointer, bus width and completion flag
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ptr_q  <= '0;
            wide_q <= 1'b0;
            irq_q  <= 1'b0;
        end else begin
            if (do_load) wide_q <= cfg_wide;
            if (state_q == ST_ADVANCE)
                ptr_q <= wide_q ? {line_base[AW-1:1], 1'b0} : line_base;
            else if (accept && !line_done)
                ptr_q <= ptr_q + (wide_q ? STEP_WIDE : STEP_NARROW);
            if (finish)       irq_q <= 1'b1;
            else if (irq_clr) irq_q <= 1'b0;
        end
    end

    // outputs
    always_comb begin
        mem_req   = (state_q == ST_XFER);
        mem_addr  = ptr_q;
        mem_lo_en = mem_req && lo_en;
        mem_hi_en = mem_req && hi_en;
        busy      = (state_q != ST_IDLE);
        irq       = irq_q;
    end

    a_r9_hold: assert property (@(posedge clk) disable iff (!rst_n)
        mem_req && !mem_rdy |=> mem_req && $stable(mem_addr)
                                && $stable(mem_lo_en) && $stable(mem_hi_en))
        else $error("beat changed before acceptance");

    a_r10_strobe: assert property (@(posedge clk) disable iff (!rst_n)
        mem_req |-> (mem_lo_en || mem_hi_en))
        else $error("beat without byte strobe");

    a_r3_narrow_lo_only: assert property (@(posedge clk) disable iff (!rst_n)
        mem_req && !wide_q |-> mem_lo_en && !mem_hi_en)
        else $error("upper strobe on 8-bit bus");

    a_r4_even_addr: assert property (@(posedge clk) disable iff (!rst_n)
        mem_req && wide_q |-> !mem_addr[0])
        else $error("odd address on 16-bit bus");

    a_r7_irq_hold: assert property (@(posedge clk) disable iff (!rst_n)
        irq && !irq_clr |=> irq)
        else $error("completion flag dropped without clear");

    a_r8_width_locked: assert property (@(posedge clk) disable iff (!rst_n)
        busy && state_q != ST_IDLE |=> $stable(wide_q))
        else $error("bus width changed during a walk");
endmodule

// File: tb/sim_winaddr_gen.sv
module sim_winaddr_gen;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        start = 1'b0;
    logic [23:0] cfg_base = '0;
    logic [12:0] cfg_bytes_m1 = '0;
    logic [12:0] cfg_stride_m1 = '0;
    logic [15:0] cfg_lines_m1 = '0;
    logic        cfg_wide = 1'b0;
    logic        irq_clr = 1'b0;
    logic        mem_rdy = 1'b0;
    logic        mem_req, mem_lo_en, mem_hi_en, busy, irq;
    logic [23:0] mem_addr;

    int tests = 0;
    int fails = 0;
    bit done_flag = 1'b0;
    logic [7:0] lfsr = 8'hA5;

    logic [23:0] ea  [0:255];
    logic        elo [0:255];
    logic        ehi [0:255];
    int          eln [0:255];
    int          en;

    always #10 clk = ~clk;

    winaddr_gen u0 (
        .clk(clk), .rst_n(rst_n), .start(start), .cfg_base(cfg_base),
        .cfg_bytes_m1(cfg_bytes_m1), .cfg_stride_m1(cfg_stride_m1),
        .cfg_lines_m1(cfg_lines_m1), .cfg_wide(cfg_wide), .irq_clr(irq_clr),
        .mem_rdy(mem_rdy), .mem_req(mem_req), .mem_addr(mem_addr),
        .mem_lo_en(mem_lo_en), .mem_hi_en(mem_hi_en), .busy(busy), .irq(irq)
    );

    // {base, bytes_m1, stride_m1, lines_m1, wide}
    localparam int NV = 6;
    localparam logic [66:0] VEC [NV] = '{
        {24'h000100, 13'd3,    13'd7,    16'd2, 1'b0},
        {24'h000201, 13'd4,    13'd15,   16'd1, 1'b1},
        {24'h123456, 13'd0,    13'd2,    16'd3, 1'b1},
        {24'h0FFFF0, 13'd5,    13'd5,    16'd1, 1'b1},
        {24'h00ABCD, 13'd0,    13'd0,    16'd0, 1'b0},
        {24'hFFFFFC, 13'd3,    13'd8191, 16'd1, 1'b0}
    };

    task automatic check(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
        tests++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic build(input logic [66:0] v);
        logic [23:0] b = v[66:43];
        int nb = int'(v[42:30]) + 1;
        int st = int'(v[29:17]) + 1;
        int nl = int'(v[16:1]) + 1;
        bit w  = v[0];
        en = 0;
        for (int l = 0; l < nl; l++) begin
            logic [23:0] s = b + 24'(l * st);
            for (int k = 0; k < nb; k++) begin
                logic [23:0] by = s + 24'(k);
                if (!w) begin
                    ea[en] = by; elo[en] = 1'b1; ehi[en] = 1'b0; eln[en] = l; en++;
                end else begin
                    logic [23:0] wd = {by[23:1], 1'b0};
                    if (k == 0 || ea[en-1] != wd) begin
                        ea[en] = wd; elo[en] = 1'b0; ehi[en] = 1'b0; eln[en] = l; en++;
                    end
                    if (by[0]) ehi[en-1] = 1'b1;
                    else       elo[en-1] = 1'b1;
                end
            end
        end
    endtask

    task automatic run_vec(input logic [66:0] v);
        int got = 0;
        bit hold_pend = 1'b0;
        logic [25:0] hold_val = '0;
        string tag;
        build(v);
        for (int cyc = 0; cyc < 3000; cyc++) begin
            @(negedge clk);
            if (cyc == 0) begin
                cfg_base = v[66:43]; cfg_bytes_m1 = v[42:30];
                cfg_stride_m1 = v[29:17]; cfg_lines_m1 = v[16:1];
                cfg_wide = v[0]; start = 1'b1;
            end else if (cyc == 3 && busy) begin
                // R8: restart attempt with different settings mid-walk
                start = 1'b1; cfg_base = 24'h777777; cfg_bytes_m1 = 13'd40;
                cfg_lines_m1 = 16'd9; cfg_wide = ~v[0];
            end else begin
                start = 1'b0;
            end
            lfsr = {lfsr[6:0], lfsr[7] ^ lfsr[5] ^ lfsr[4] ^ lfsr[3]};
            mem_rdy = lfsr[0] | lfsr[2];
            #1;
            if (cyc == 2) check(busy == 1'b1, "R2 busy during walk", 32'(busy), 1);
            if (hold_pend) begin
                check(mem_req && {mem_addr, mem_lo_en, mem_hi_en} == hold_val,
                      "R9 beat held", 32'({mem_addr, mem_lo_en, mem_hi_en}), 32'(hold_val));
                hold_pend = 1'b0;
            end
            if (mem_req && !mem_rdy) begin
                hold_pend = 1'b1;
                hold_val = {mem_addr, mem_lo_en, mem_hi_en};
            end
            if (mem_req && mem_rdy) begin
                if (got >= en) begin
                    check(1'b0, "R6 extra beat", 32'(got), 32'(en));
                end else begin
                    tag = (eln[got] > 0) ? "R5 line base" : (v[0] ? "R4 wide beat" : "R3 narrow beat");
                    check(mem_addr == ea[got] && mem_lo_en == elo[got] && mem_hi_en == ehi[got],
                          tag, 32'({mem_addr, mem_lo_en, mem_hi_en}),
                          32'({ea[got], elo[got], ehi[got]}));
                    check(mem_lo_en || mem_hi_en, "R10 strobe present", 32'({mem_lo_en, mem_hi_en}), 1);
                end
                got++;
            end
            if (cyc > 1 && !busy) break;
        end
        start = 1'b0;
        mem_rdy = 1'b0;
        check(got == en, "R6 beat count", 32'(got), 32'(en));
        check(irq == 1'b1, "R6 irq after last line", 32'(irq), 1);
        check(busy == 1'b0, "R2 busy cleared", 32'(busy), 0);
    endtask

    task automatic clear_irq();
        @(negedge clk); irq_clr = 1'b1;
        @(negedge clk); irq_clr = 1'b0;
        #1;
    endtask

    initial begin
        repeat (3) @(negedge clk);
        #1;
        check(!mem_req && !busy && !irq, "R1 reset state",
              32'({mem_req, busy, irq}), 0);
        rst_n = 1'b1;
        @(negedge clk);
        // R8 also: no beat issued without a start
        #1; check(!mem_req && !busy, "R1 idle after reset", 32'({mem_req, busy}), 0);

        for (int i = 0; i < NV; i++) begin
            run_vec(VEC[i]);
            if (i == 0) begin
                repeat (4) @(negedge clk);
                #1; check(irq == 1'b1, "R7 irq held", 32'(irq), 1);
            end
            clear_irq();
            check(irq == 1'b0, "R7 irq cleared", 32'(irq), 0);
        end

        // R7: clear pulsed in the cycle the final beat is accepted
        build(VEC[4]);
        @(negedge clk);
        cfg_base = 24'h000010; cfg_bytes_m1 = '0; cfg_lines_m1 = '0;
        cfg_wide = 1'b0; start = 1'b1; mem_rdy = 1'b1;
        @(negedge clk); start = 1'b0;
        @(negedge clk); irq_clr = 1'b1;
        #1; check(mem_req == 1'b1, "R3 single beat issued", 32'(mem_req), 1);
        @(negedge clk); irq_clr = 1'b0; mem_rdy = 1'b0;
        #1; check(irq == 1'b1, "R7 set wins over clear", 32'(irq), 1);
        clear_irq();

        done_flag = 1'b1;
        $display("  [TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done_flag) begin
            tests++; fails++;
            $display("FAIL watchdog expired actual=timeout expected=done");
            $display("  [TB] %0d tests run, %0d failed", tests, fails);
            $finish;
        end
    end
endmodule